// File: doc/BRIEF.md
# Paired-Page Translation Entry Array

This block is a small, fully associative translation buffer that a privileged software routine maintains through three commands. Each entry maps an aligned pair of virtual pages, an even one and an odd one, onto two independent physical frames. The pair size follows a 6-bit page-size code stored in the entry. An entry is either bound to one address-space identifier or marked global. A per-entry not-exist flag takes it out of all lookups.

Software works through a set of 64-bit staging registers held inside the block: an index register, an entry-high register carrying the virtual page number, two entry-low registers (one per page of the pair), the current address-space register, and a refill set. The refill set is a mode register whose bit 0 selects refill operation, plus a refill entry-high and two refill entry-low registers. A search command looks the entry-high page number and the current address space up in every entry in one cycle. A read command unloads the indexed entry into the staging registers. A write command loads the staging registers into the indexed entry, unless the index register says the slot is to be dropped. Choosing the slot to replace, walking page tables and translating load and store addresses are left to surrounding logic.

Top module: `pair_tlb`

## Requirements
- R1: After reset every entry is marked not-exist and all nine staging registers read zero. A read command on any slot right after reset therefore returns not-exist.
- R2: The register selector codes are: 0 index, 1 entry-high, 2 entry-low 0, 3 entry-low 1, 4 current address space, 5 refill mode, 6 refill entry-high, 7 refill entry-low 0, 8 refill entry-low 1. A write stores all 64 bits and the read port returns them unchanged. If a command is issued in the same cycle, the register write is dropped.
- R3: A search hits an entry only when all of these hold: the entry is not marked not-exist; its global bit is set or its 10-bit address-space tag equals bits [9:0] of the current address-space register; and its page number matches. If several entries hit, the lowest slot number wins.
- R4: The page-number compare uses entry-high bits [47:13]. Every bit at or below the entry's page-size code ps is ignored, because the pair mask is (1 << (ps+1)) - 1. Both pages of the pair therefore hit the same entry.
- R5: The index register layout is: slot number in bits [11:0], page-size code in [29:24], not-exist flag in bit 31. A search hit writes the slot number and the hit entry's page size and leaves every other bit, including bit 31, unchanged. A miss sets bit 31 only.
- R6: A write with index bit 31 clear loads the slot selected by the low index bits and clears its not-exist flag. The loaded entry takes: the page number (entry-high [47:13] with the mask bits cleared); the current address-space tag; global = AND of bit 6 of both entry-low words; and for each page V [0], D [1], PLV [3:2], MAT [5:4], NR [61], NX [62], RPLV [63] and the frame number from [47:12] with the bits below ps cleared.
- R7: A write with index bit 31 set only marks the selected slot not-exist. No other slot and no other field changes.
- R8: When refill-mode bit 0 is set, a write takes entry-high and both entry-low words from the refill set, and the page-size code from refill entry-high bits [5:0].
- R9: A read of a live slot sets index [29:24] to the slot's page size and keeps the other index bits. It sets entry-high to the stored page number at [47:13] with all other bits zero. It rebuilds both entry-low words in the R6 layout, with the slot's global bit at bit 6 and zeros elsewhere. It copies the slot's tag into address-space bits [9:0].
- R10: A read of a not-exist slot sets index bit 31 and clears entry-high and both entry-low registers. The address-space register is left alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 2 | Command: 0 none, 1 search, 2 read, 3 write |
| csr_we | input | 1 | Staging register write strobe (dropped when cmd_op is non-zero) |
| csr_wsel | input | 4 | Register selected for writing (codes in R2) |
| csr_wdata | input | 64 | Register write data |
| csr_rsel | input | 4 | Register selected for reading |
| csr_rdata | output | 64 | Selected register value, combinational |

## Verification
Some properties are checked on every clock by assertions. A miss always raises the index not-exist bit, and a read of a dropped slot always clears the three staging words. A live read copies the address-space tag. The priority grant always names a hitting slot and no lower one hits. A slot being dropped always comes out not-exist, and a loaded slot always comes out live. Other behaviour is shown only by the bench's scenarios against its reference model: the exact field packing and the page and frame masking for different sizes, the odd-page hit, the global-versus-tag rule across address spaces, the refill source choice, and the fact that a drop leaves neighbouring slots intact.

// File: rtl/pair_tlb_pkg.sv
package pair_tlb_pkg;

  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_SEARCH = 2'd1,
    OP_READ   = 2'd2,
    OP_WRITE  = 2'd3
  } op_t;

  localparam logic [3:0] SEL_IDX   = 4'd0;
  localparam logic [3:0] SEL_EHI   = 4'd1;
  localparam logic [3:0] SEL_LO0   = 4'd2;
  localparam logic [3:0] SEL_LO1   = 4'd3;
  localparam logic [3:0] SEL_ASID  = 4'd4;
  localparam logic [3:0] SEL_RMODE = 4'd5;
  localparam logic [3:0] SEL_REHI  = 4'd6;
  localparam logic [3:0] SEL_RLO0  = 4'd7;
  localparam logic [3:0] SEL_RLO1  = 4'd8;

  localparam int IDX_NE_BIT  = 31;
  localparam int IDX_PS_LSB  = 24;
  localparam int ASID_W      = 10;
  localparam int VPN_W       = 35;  // bits [47:13]
  localparam int PPN_W       = 36;  // bits [47:12]

  typedef struct packed {
    logic             v;
    logic             d;
    logic [1:0]       plv;
    logic [1:0]       mat;
    logic             nr;
    logic             nx;
    logic             rplv;
    logic [PPN_W-1:0] ppn;
  } page_t;

  typedef struct packed {
    logic              ne;
    logic              g;
    logic [ASID_W-1:0] asid;
    logic [5:0]        ps;
    logic [VPN_W-1:0]  vpn;
    page_t             p0;
    page_t             p1;
  } entry_t;

  // Bits of [47:13] that survive the pair mask for page-size code ps.
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [5:0] ps);
    logic [VPN_W-1:0] k;
    for (int b = 0; b < VPN_W; b++) k[b] = (b + 13) > int'(ps);
    return k;
  endfunction

  // Bits of [47:12] that survive the half mask (one page) for code ps.
  function automatic logic [PPN_W-1:0] ppn_keep(input logic [5:0] ps);
    logic [PPN_W-1:0] k;
    for (int b = 0; b < PPN_W; b++) k[b] = (b + 12) >= int'(ps);
    return k;
  endfunction

  function automatic page_t pack_page(input logic [63:0] lo, input logic [5:0] ps);
    page_t p;
    p.v    = lo[0];
    p.d    = lo[1];
    p.plv  = lo[3:2];
    p.mat  = lo[5:4];
    p.nr   = lo[61];
    p.nx   = lo[62];
    p.rplv = lo[63];
    p.ppn  = lo[47:12] & ppn_keep(ps);
    return p;
  endfunction

  function automatic logic [63:0] unpack_page(input page_t p, input logic g);
    logic [63:0] lo;
    lo        = '0;
    lo[0]     = p.v;
    lo[1]     = p.d;
    lo[3:2]   = p.plv;
    lo[5:4]   = p.mat;
    lo[6]     = g;
    lo[47:12] = p.ppn;
    lo[61]    = p.nr;
    lo[62]    = p.nx;
    lo[63]    = p.rplv;
    return lo;
  endfunction

endpackage

// File: rtl/pair_tlb_entry.sv
module pair_tlb_entry
  import pair_tlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic              kill_en,
  input  entry_t            load_data,
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              hit,
  output entry_t            stored
);

  entry_t ent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent    <= '0;
      ent.ne <= 1'b1;
    end else if (kill_en) begin
      ent.ne <= 1'b1;
    end else if (load_en) begin
      ent <= load_data;
    end
  end

  logic tag_ok;
  logic vpn_ok;
  assign tag_ok = ent.g || (ent.asid == key_asid);
  assign vpn_ok = (key_vpn & vpn_keep(ent.ps)) == ent.vpn;
  assign hit    = !ent.ne && tag_ok && vpn_ok;
  assign stored = ent;

  assert_drop_marks_ne_R7: assert property (@(posedge clk) disable iff (!rst_n)
    kill_en |=> stored.ne);

  assert_load_makes_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && !kill_en) |=> !stored.ne);

endmodule

// File: rtl/pair_tlb_prio.sv
module pair_tlb_prio #(
  parameter int N = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N-1:0]         hits,
  output logic                 any,
  output logic [$clog2(N)-1:0] win
);

  localparam int IW = $clog2(N);

  always_comb begin
    any = 1'b0;
    win = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        win = IW'(i);
      end
    end
  end

  assert_grant_is_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> hits[win]);

  assert_grant_is_lowest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((hits & ((N'(1) << win) - N'(1))) == '0));

endmodule

// File: rtl/pair_tlb.sv
module pair_tlb
  import pair_tlb_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  cmd_op,
  input  logic        csr_we,
  input  logic [3:0]  csr_wsel,
  input  logic [63:0] csr_wdata,
  input  logic [3:0]  csr_rsel,
  output logic [63:0] csr_rdata
);

  localparam int IW = $clog2(ENTRIES);

  logic [63:0] r_idx, r_ehi, r_lo0, r_lo1, r_asid;
  logic [63:0] r_rmode, r_rehi, r_rlo0, r_rlo1;

  op_t op;
  assign op = op_t'(cmd_op);

  logic is_search, is_read, is_write;
  assign is_search = (op == OP_SEARCH);
  assign is_read   = (op == OP_READ);
  assign is_write  = (op == OP_WRITE);

  // Slot addressed by the index register
  logic [IW-1:0] tgt;
  assign tgt = r_idx[IW-1:0];

  // Write source selection (normal or refill set)
  logic        use_refill;
  logic [63:0] src_ehi, src_lo0, src_lo1;
  logic [5:0]  src_ps;
  entry_t      new_ent;

  assign use_refill = r_rmode[0];
  assign src_ehi    = use_refill ? r_rehi : r_ehi;
  assign src_lo0    = use_refill ? r_rlo0 : r_lo0;
  assign src_lo1    = use_refill ? r_rlo1 : r_lo1;
  assign src_ps     = use_refill ? r_rehi[5:0] : r_idx[IDX_PS_LSB +: 6];

  always_comb begin
    new_ent      = '0;
    new_ent.ne   = 1'b0;
    new_ent.g    = src_lo0[6] & src_lo1[6];
    new_ent.asid = r_asid[ASID_W-1:0];
    new_ent.ps   = src_ps;
    new_ent.vpn  = src_ehi[47:13] & vpn_keep(src_ps);
    new_ent.p0   = pack_page(src_lo0, src_ps);
    new_ent.p1   = pack_page(src_lo1, src_ps);
  end

  logic write_drop, write_load;
  assign write_drop = is_write && r_idx[IDX_NE_BIT];
  assign write_load = is_write && !r_idx[IDX_NE_BIT];

  // Entry array
  logic [ENTRIES-1:0] hits;
  logic [ENTRIES-1:0] load_vec, kill_vec;
  entry_t             ents [ENTRIES];

  for (genvar gi = 0; gi < ENTRIES; gi++) begin : g_ent
    assign load_vec[gi] = write_load && (tgt == IW'(gi));
    assign kill_vec[gi] = write_drop && (tgt == IW'(gi));

    pair_tlb_entry u_ent (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_en  (load_vec[gi]),
      .kill_en  (kill_vec[gi]),
      .load_data(new_ent),
      .key_vpn  (r_ehi[47:13]),
      .key_asid (r_asid[ASID_W-1:0]),
      .hit      (hits[gi]),
      .stored   (ents[gi])
    );
  end

  logic          hit_any;
  logic [IW-1:0] hit_slot;

  pair_tlb_prio #(.N(ENTRIES)) u_prio (
    .clk  (clk),
    .rst_n(rst_n),
    .hits (hits),
    .any  (hit_any),
    .win  (hit_slot)
  );

  entry_t rd_ent, hit_ent;
  assign rd_ent  = ents[tgt];
  assign hit_ent = ents[hit_slot];

  // Staging registers and command effects
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_idx   <= '0;
      r_ehi   <= '0;
      r_lo0   <= '0;
      r_lo1   <= '0;
      r_asid  <= '0;
      r_rmode <= '0;
      r_rehi  <= '0;
      r_rlo0  <= '0;
      r_rlo1  <= '0;
    end else if (op != OP_NONE) begin
      case (op)
        OP_SEARCH: begin
          if (hit_any) begin
            r_idx[11:0]             <= 12'(hit_slot);
            r_idx[IDX_PS_LSB +: 6]  <= hit_ent.ps;
          end else begin
            r_idx[IDX_NE_BIT]       <= 1'b1;
          end
        end
        OP_READ: begin
          if (rd_ent.ne) begin
            r_idx[IDX_NE_BIT] <= 1'b1;
            r_ehi             <= '0;
            r_lo0             <= '0;
            r_lo1             <= '0;
          end else begin
            r_idx[IDX_PS_LSB +: 6]  <= rd_ent.ps;
            r_ehi                   <= {16'd0, rd_ent.vpn, 13'd0};
            r_lo0                   <= unpack_page(rd_ent.p0, rd_ent.g);
            r_lo1                   <= unpack_page(rd_ent.p1, rd_ent.g);
            r_asid[ASID_W-1:0]      <= rd_ent.asid;
          end
        end
        default: ;
      endcase
    end else if (csr_we) begin
      case (csr_wsel)
        SEL_IDX:   r_idx   <= csr_wdata;
        SEL_EHI:   r_ehi   <= csr_wdata;
        SEL_LO0:   r_lo0   <= csr_wdata;
        SEL_LO1:   r_lo1   <= csr_wdata;
        SEL_ASID:  r_asid  <= csr_wdata;
        SEL_RMODE: r_rmode <= csr_wdata;
        SEL_REHI:  r_rehi  <= csr_wdata;
        SEL_RLO0:  r_rlo0  <= csr_wdata;
        SEL_RLO1:  r_rlo1  <= csr_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (csr_rsel)
      SEL_IDX:   csr_rdata = r_idx;
      SEL_EHI:   csr_rdata = r_ehi;
      SEL_LO0:   csr_rdata = r_lo0;
      SEL_LO1:   csr_rdata = r_lo1;
      SEL_ASID:  csr_rdata = r_asid;
      SEL_RMODE: csr_rdata = r_rmode;
      SEL_REHI:  csr_rdata = r_rehi;
      SEL_RLO0:  csr_rdata = r_rlo0;
      SEL_RLO1:  csr_rdata = r_rlo1;
      default:   csr_rdata = '0;
    endcase
  end

  assert_miss_sets_ne_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_search && !hit_any) |=> r_idx[IDX_NE_BIT]);

  assert_dead_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && rd_ent.ne) |=> (r_ehi == '0 && r_lo0 == '0 && r_lo1 == '0 && r_idx[IDX_NE_BIT]));

  assert_live_read_tag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (is_read && !rd_ent.ne) |=> (r_asid[ASID_W-1:0] == $past(rd_ent.asid)));

  assert_one_slot_touched_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load_vec | kill_vec));

endmodule

// File: tb/pair_tlb_tb.sv
module pair_tlb_tb;

  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic        csr_we = 1'b0;
  logic [3:0]  csr_wsel = 4'd0;
  logic [63:0] csr_wdata = '0;
  logic [3:0]  csr_rsel = 4'd0;
  logic [63:0] csr_rdata;

  always #10 clk = ~clk;  // 50 MHz

  pair_tlb #(.ENTRIES(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .csr_we(csr_we),
    .csr_wsel(csr_wsel), .csr_wdata(csr_wdata), .csr_rsel(csr_rsel),
    .csr_rdata(csr_rdata)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Reference model state
  logic [63:0] m_reg [9];
  bit          m_ne  [N];
  logic [63:0] m_vpn [N];
  logic [63:0] m_lo0 [N];
  logic [63:0] m_lo1 [N];
  int          m_ps  [N];
  int          m_tag [N];
  bit          m_g   [N];

  localparam logic [63:0] VA_BITS = 64'h0000_FFFF_FFFF_E000;
  localparam logic [63:0] PA_BITS = 64'h0000_FFFF_FFFF_F000;
  localparam logic [63:0] FLAGS   = 64'hE000_0000_0000_003F;

  function automatic logic [63:0] pair_mask(input int ps);
    return (64'd1 << (ps + 1)) - 64'd1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek(input logic [3:0] sel, output logic [63:0] v);
    csr_rsel = sel;
    #1;
    v = csr_rdata;
  endtask

  task automatic set_reg(input logic [3:0] sel, input logic [63:0] val);
    @(negedge clk);
    csr_we = 1'b1; csr_wsel = sel; csr_wdata = val;
    @(negedge clk);
    csr_we = 1'b0;
    m_reg[sel] = val;
  endtask

  function automatic int slot();
    return int'(m_reg[0] % N);
  endfunction

  task automatic model_search();
    int found = -1;
    for (int i = 0; i < N; i++) begin
      if (found < 0 && !m_ne[i] && (m_g[i] || m_tag[i] == int'(m_reg[4][9:0])) &&
          ((m_reg[1] & VA_BITS & ~pair_mask(m_ps[i])) == m_vpn[i]))
        found = i;
    end
    if (found >= 0) begin
      m_reg[0][11:0]  = 12'(found);
      m_reg[0][29:24] = 6'(m_ps[found]);
    end else begin
      m_reg[0][31] = 1'b1;
    end
  endtask

  task automatic model_read();
    int t = slot();
    if (m_ne[t]) begin
      m_reg[0][31] = 1'b1;
      m_reg[1] = '0; m_reg[2] = '0; m_reg[3] = '0;
    end else begin
      m_reg[0][29:24] = 6'(m_ps[t]);
      m_reg[1] = m_vpn[t];
      m_reg[2] = m_lo0[t];
      m_reg[3] = m_lo1[t];
      m_reg[4][9:0] = 10'(m_tag[t]);
    end
  endtask

  task automatic model_write();
    int t = slot();
    bit rf;
    logic [63:0] e, l0, l1, mk;
    int ps;
    bit g;
    if (m_reg[0][31]) begin
      m_ne[t] = 1;
    end else begin
      rf = m_reg[5][0];
      e  = rf ? m_reg[6] : m_reg[1];
      l0 = rf ? m_reg[7] : m_reg[2];
      l1 = rf ? m_reg[8] : m_reg[3];
      ps = rf ? int'(m_reg[6][5:0]) : int'(m_reg[0][29:24]);
      mk = pair_mask(ps);
      g  = l0[6] & l1[6];
      m_ne[t]  = 0;
      m_g[t]   = g;
      m_ps[t]  = ps;
      m_tag[t] = int'(m_reg[4][9:0]);
      m_vpn[t] = e & VA_BITS & ~mk;
      m_lo0[t] = (l0 & FLAGS) | (l0 & PA_BITS & ~(mk >> 1)) | (64'(g) << 6);
      m_lo1[t] = (l1 & FLAGS) | (l1 & PA_BITS & ~(mk >> 1)) | (64'(g) << 6);
    end
  endtask

  task automatic do_op(input logic [1:0] op);
    @(negedge clk);
    cmd_op = op;
    @(negedge clk);
    cmd_op = 2'd0;
    case (op)
      2'd1: model_search();
      2'd2: model_read();
      2'd3: model_write();
      default: ;
    endcase
  endtask

  task automatic compare_all(input string tag);
    logic [63:0] v;
    for (int s = 0; s < 5; s++) begin
      peek(4'(s), v);
      chk($sformatf("%s reg%0d", tag, s), v, m_reg[s]);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    for (int i = 0; i < 9; i++) m_reg[i] = '0;
    for (int i = 0; i < N; i++) begin
      m_ne[i] = 1; m_vpn[i] = '0; m_lo0[i] = '0; m_lo1[i] = '0;
      m_ps[i] = 0; m_tag[i] = 0; m_g[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int s = 0; s < 9; s++) begin
      peek(4'(s), v);
      chk($sformatf("R1 reset reg%0d", s), v, '0);
    end
    set_reg(4'd0, 64'd6);
    do_op(2'd2);
    peek(4'd0, v);
    chk("R1 read after reset not-exist", v[31], 1'b1);
    compare_all("R1");

    // R2: register write and readback, dropped when command active
    set_reg(4'd8, 64'hDEAD_BEEF_0123_4567);
    peek(4'd8, v);
    chk("R2 refill lo1 readback", v, 64'hDEAD_BEEF_0123_4567);
    @(negedge clk);
    cmd_op = 2'd2; csr_we = 1'b1; csr_wsel = 4'd5; csr_wdata = 64'h1;
    @(negedge clk);
    cmd_op = 2'd0; csr_we = 1'b0;
    model_read();
    peek(4'd5, v);
    chk("R2 write dropped under command", v, 64'd0);

    // R6 / R9: load slot 3 then read it back
    set_reg(4'd4, 64'd5);
    set_reg(4'd0, 64'h0C00_0003);
    set_reg(4'd1, 64'h0000_1234_5678_B000);
    set_reg(4'd2, 64'hE000_0000_0ABC_D05F);
    set_reg(4'd3, 64'h2000_0000_0ABC_E013);
    do_op(2'd3);
    set_reg(4'd4, 64'h1F);
    set_reg(4'd1, 64'h0);
    do_op(2'd2);
    compare_all("R6 R9 slot3");
    peek(4'd4, v);
    chk("R9 tag copied", v, 64'd5);

    // R3/R4: global entry with 2 MB pages in slot 1, loaded under tag 7
    set_reg(4'd4, 64'd7);
    set_reg(4'd0, 64'h1500_0001);
    set_reg(4'd1, 64'h0000_0040_0060_0000);
    set_reg(4'd2, 64'h41);
    set_reg(4'd3, 64'h43);
    do_op(2'd3);
    set_reg(4'd4, 64'd5);
    set_reg(4'd0, 64'h0);
    set_reg(4'd1, 64'h0000_0040_007F_F123);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R3 R4 global hit odd page", v, 64'h1500_0001);
    set_reg(4'd1, 64'h0000_0040_0080_0000);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R4 R5 miss above mask", v, 64'h9500_0001);
    set_reg(4'd1, 64'h0000_0040_0050_0000);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R5 hit keeps not-exist bit", v, 64'h9500_0001);
    compare_all("R5");

    // R3: lowest slot wins among equal entries; tag mismatch misses
    set_reg(4'd1, 64'h0000_0000_7777_0000);
    set_reg(4'd2, 64'h1);
    set_reg(4'd3, 64'h1);
    set_reg(4'd0, 64'h0C00_0009);
    do_op(2'd3);
    set_reg(4'd0, 64'h0C00_0005);
    do_op(2'd3);
    set_reg(4'd0, 64'h0);
    set_reg(4'd1, 64'h0000_0000_7777_1000);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R3 lowest slot wins", v, 64'h0C00_0005);
    set_reg(4'd4, 64'd6);
    set_reg(4'd0, 64'h0);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R3 tag mismatch misses", v, 64'h8000_0000);
    set_reg(4'd4, 64'd5);

    // R7: drop slot 5, slot 9 now wins, slot 9 intact
    set_reg(4'd0, 64'h8000_0005);
    do_op(2'd3);
    set_reg(4'd0, 64'h0);
    set_reg(4'd1, 64'h0000_0000_7777_0000);
    do_op(2'd1);
    peek(4'd0, v);
    chk("R7 dropped slot skipped", v, 64'h0C00_0009);
    do_op(2'd2);
    compare_all("R7 slot9 intact");

    // R10: read of dropped slot 5
    set_reg(4'd0, 64'h5);
    do_op(2'd2);
    peek(4'd1, v);
    chk("R10 entry-high cleared", v, 64'h0);
    compare_all("R10");

    // R8: refill source with 16 KB pages into slot 7
    set_reg(4'd5, 64'h1);
    set_reg(4'd6, 64'h0000_0001_2345_600E);
    set_reg(4'd7, 64'h8000_0000_0555_5047);
    set_reg(4'd8, 64'h4000_0000_0555_D0C1);
    set_reg(4'd1, 64'h0000_0000_1111_0000);
    set_reg(4'd0, 64'h0C00_0007);
    do_op(2'd3);
    set_reg(4'd5, 64'h0);
    do_op(2'd2);
    peek(4'd0, v);
    chk("R8 page size from refill", v[29:24], 64'd14);
    compare_all("R8");
    set_reg(4'd1, 64'h0000_0001_2345_7FFF);
    set_reg(4'd0, 64'h0);
    do_op(2'd1);
    compare_all("R8 R4 search refill slot");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule